// File: doc/BRIEF.md
# Dual-Channel Register-Mapped GPIO Controller

This block gives software control of up to two banks of general-purpose pins. Each bank has up to 32 pins. Each bank has an output-value register and a direction register. A direction bit of 1 switches that pin's output driver off, so the pin is an input. A 0 makes the pin an output. Pin inputs are resynchronised into the clock domain. Reading a bank's data register returns the live input level on input pins and the stored output value on output pins.

Each bank raises a single status flag when any of its synchronised input bits changes level. The two flags are masked by a two-bit enable register and by a master enable. Together they form one registered interrupt line. Software acknowledges an event by writing back the status value it read. A 1 in the written value clears that flag. A 0 leaves it unchanged.

Access uses a simple single-cycle register bus with byte addresses. A write takes effect at the clock edge where `bus_en` and `bus_wr` are both high. Read data is combinational while `bus_en` is high and `bus_wr` is low. The bus has no back-pressure and no wait states: every access completes in its own cycle.

Top module: `gpio_dual_ctrl`

## Requirements
- R1: After reset, every direction bit is 1, so `chN_oe` is all zero. Every output register holds its reset parameter, which defaults to 0. The status register reads 0 and `irq` is low.
- R2: A write to 0x000 (bank 1) or 0x008 (bank 2) loads the bank's output register. The value appears on `chN_out` in the next cycle.
- R3: A write to 0x004 (bank 1) or 0x00C (bank 2) loads the direction register, where 1 means input and 0 means output. `chN_oe` equals the inverse of that register. Reading the address returns the register.
- R4: A data read returns the synchronised pin level on input bits and the output register on output bits. Bits at or above the bank width read as 0. A pin change is visible in the read two clock edges after it is applied.
- R5: Status bit 0 (bank 1) or bit 1 (bank 2) at 0x120 sets on the third clock edge after any input bit of that bank changes. This happens whatever the enable settings are.
- R6: A write to 0x120 clears exactly the status bits written as 1. Bits written as 0 keep their value. If a clear and a new change of the same bank fall in the same cycle, the bit stays set.
- R7: `irq` is a register. It goes high one edge after the master enable is set and (status AND enable) is nonzero, and goes low one edge after that condition ends.
- R8: The master enable is bit 31 at 0x11C. All other bits of that register are ignored and read as 0.
- R9: The enable register at 0x128 holds bit 0 for bank 1 and bit 1 for bank 2. Its other bits read as 0.
- R10: Addresses other than the seven registers read as 0, and writes to them change nothing.
- R11: Loading the synchroniser after reset never sets a status bit, even when pins are nonzero during reset.
- R12: With the dual-bank parameter cleared, the bank-2 addresses are unmapped and enable bit 1 is not writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 9 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (0 when idle) |
| ch1_out | output | CH1_WIDTH | Bank 1 output values |
| ch1_oe | output | CH1_WIDTH | Bank 1 driver enables |
| ch1_in | input | CH1_WIDTH | Bank 1 pin levels |
| ch2_out | output | CH2_WIDTH | Bank 2 output values |
| ch2_oe | output | CH2_WIDTH | Bank 2 driver enables |
| ch2_in | input | CH2_WIDTH | Bank 2 pin levels |
| irq | output | 1 | Interrupt request |

## Verification
A wrong output or direction register shows on the pins one edge after the write, and in a readback in the same cycle. A wrong synchroniser depth or a wrong reset-fill guard shows as a status bit that sets one edge early or late, or that sets with no pin change. Both are caught by sampling status on exactly the second and third edges after a pin change. An error in the enable gating or in the write-one-to-clear logic shows on `irq` within two edges of the write that should change it.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int ADDR_W = 9;
  localparam int DATA_W = 32;
  localparam logic [ADDR_W-1:0] A_B1_DATA = 9'h000;
  localparam logic [ADDR_W-1:0] A_B1_DIR  = 9'h004;
  localparam logic [ADDR_W-1:0] A_B2_DATA = 9'h008;
  localparam logic [ADDR_W-1:0] A_B2_DIR  = 9'h00C;
  localparam logic [ADDR_W-1:0] A_MASTER  = 9'h11C;
  localparam logic [ADDR_W-1:0] A_STATUS  = 9'h120;
  localparam logic [ADDR_W-1:0] A_ENABLE  = 9'h128;
  localparam int MASTER_BIT = 31;
  localparam int NUM_BANKS = 2;
endpackage

// File: rtl/gpio_bank.sv
module gpio_bank #(
  parameter int W = 32,
  parameter logic [31:0] OUT_RST = 32'h0,
  parameter logic [31:0] DIR_RST = 32'hFFFF_FFFF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_out,
  input  logic         wr_dir,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  output logic [W-1:0] rd_data,
  output logic [W-1:0] rd_dir,
  output logic         chg
);
  localparam logic [1:0] FILLED = 2'd3;

  logic [W-1:0] out_q, dir_q, sy1_q, sy2_q, prev_q;
  logic [1:0]   fill_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q  <= OUT_RST[W-1:0];
      dir_q  <= DIR_RST[W-1:0];
      sy1_q  <= '0;
      sy2_q  <= '0;
      prev_q <= '0;
      fill_q <= '0;
    end else begin
      if (wr_out) out_q <= wdata;
      if (wr_dir) dir_q <= wdata;
      sy1_q  <= pin_in;
      sy2_q  <= sy1_q;
      prev_q <= sy2_q;
      if (fill_q != FILLED) fill_q <= fill_q + 2'd1;
    end
  end

  // change is only meaningful once all three sample stages hold real data
  assign chg     = (fill_q == FILLED) && (|(sy2_q ^ prev_q));
  assign pin_out = out_q;
  assign pin_oe  = ~dir_q;
  assign rd_dir  = dir_q;
  assign rd_data = (dir_q & sy2_q) | (~dir_q & out_q);

  // R2
  out_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_out |=> pin_out == $past(wdata));
  // R3
  dir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> pin_oe == ~$past(wdata));
endmodule

// File: rtl/gpio_irq.sv
module gpio_irq #(
  parameter int NB = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_master,
  input  logic          wr_status,
  input  logic          wr_enable,
  input  logic          wd_msb,
  input  logic [NB-1:0] wd_lo,
  input  logic [NB-1:0] chg,
  output logic          master_q,
  output logic [NB-1:0] status_q,
  output logic [NB-1:0] enable_q,
  output logic          irq_q
);
  logic [NB-1:0] clr;

  assign clr = wr_status ? wd_lo : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      master_q <= 1'b0;
      status_q <= '0;
      enable_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      if (wr_master) master_q <= wd_msb;
      if (wr_enable) enable_q <= wd_lo;
      status_q <= (status_q & ~clr) | chg;
      irq_q    <= master_q && (|(status_q & enable_q));
    end
  end

  // R7
  master_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !master_q |=> !irq_q);
  // R7
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(|(status_q & enable_q)));
  // R5
  status_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chg[0] |=> status_q[0]);
  // R6
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_status && wd_lo[0] && !chg[0]) |=> !status_q[0]);
  // R6
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q[0] && !(wr_status && wd_lo[0])) |=> status_q[0]);
endmodule

// File: rtl/gpio_dual_ctrl.sv
module gpio_dual_ctrl
  import gpio_pkg::*;
#(
  parameter int          CH1_WIDTH   = 32,
  parameter int          CH2_WIDTH   = 32,
  parameter bit          DUAL        = 1'b1,
  parameter logic [31:0] CH1_OUT_RST = 32'h0,
  parameter logic [31:0] CH1_DIR_RST = 32'hFFFF_FFFF,
  parameter logic [31:0] CH2_OUT_RST = 32'h0,
  parameter logic [31:0] CH2_DIR_RST = 32'hFFFF_FFFF
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_en,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic [CH1_WIDTH-1:0] ch1_out,
  output logic [CH1_WIDTH-1:0] ch1_oe,
  input  logic [CH1_WIDTH-1:0] ch1_in,
  output logic [CH2_WIDTH-1:0] ch2_out,
  output logic [CH2_WIDTH-1:0] ch2_oe,
  input  logic [CH2_WIDTH-1:0] ch2_in,
  output logic                 irq
);
  localparam logic [NUM_BANKS-1:0] EN_MASK = DUAL ? 2'b11 : 2'b01;

  initial begin
    width_legal_chk: assert (CH1_WIDTH >= 1 && CH1_WIDTH <= 32 &&
                             CH2_WIDTH >= 1 && CH2_WIDTH <= 32);
  end

  logic wr;
  logic hit_b1d, hit_b1r, hit_b2d, hit_b2r, hit_m, hit_s, hit_e;
  logic [NUM_BANKS-1:0] chg;
  logic [CH1_WIDTH-1:0] b1_rd, b1_dir;
  logic [CH2_WIDTH-1:0] b2_rd, b2_dir;
  logic [DATA_W-1:0] b1_rd32, b1_dir32, b2_rd32, b2_dir32, mux;
  logic master_q, irq_q;
  logic [NUM_BANKS-1:0] status_q, enable_q;

  assign wr      = bus_en & bus_wr;
  assign hit_b1d = (bus_addr == A_B1_DATA);
  assign hit_b1r = (bus_addr == A_B1_DIR);
  assign hit_b2d = DUAL && (bus_addr == A_B2_DATA);
  assign hit_b2r = DUAL && (bus_addr == A_B2_DIR);
  assign hit_m   = (bus_addr == A_MASTER);
  assign hit_s   = (bus_addr == A_STATUS);
  assign hit_e   = (bus_addr == A_ENABLE);

  gpio_bank #(.W(CH1_WIDTH), .OUT_RST(CH1_OUT_RST), .DIR_RST(CH1_DIR_RST)) u_b1 (
    .clk(clk), .rst_n(rst_n),
    .wr_out(wr && hit_b1d), .wr_dir(wr && hit_b1r),
    .wdata(bus_wdata[CH1_WIDTH-1:0]), .pin_in(ch1_in),
    .pin_out(ch1_out), .pin_oe(ch1_oe),
    .rd_data(b1_rd), .rd_dir(b1_dir), .chg(chg[0])
  );

  generate
    if (DUAL) begin : g_b2
      gpio_bank #(.W(CH2_WIDTH), .OUT_RST(CH2_OUT_RST), .DIR_RST(CH2_DIR_RST)) u_b2 (
        .clk(clk), .rst_n(rst_n),
        .wr_out(wr && hit_b2d), .wr_dir(wr && hit_b2r),
        .wdata(bus_wdata[CH2_WIDTH-1:0]), .pin_in(ch2_in),
        .pin_out(ch2_out), .pin_oe(ch2_oe),
        .rd_data(b2_rd), .rd_dir(b2_dir), .chg(chg[1])
      );
    end else begin : g_nob2
      logic unused_b2;
      assign unused_b2 = ^ch2_in;
      assign ch2_out = '0;
      assign ch2_oe  = '0;
      assign b2_rd   = '0;
      assign b2_dir  = '0;
      assign chg[1]  = 1'b0;
    end
  endgenerate

  gpio_irq #(.NB(NUM_BANKS)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .wr_master(wr && hit_m), .wr_status(wr && hit_s), .wr_enable(wr && hit_e),
    .wd_msb(bus_wdata[MASTER_BIT]), .wd_lo(bus_wdata[NUM_BANKS-1:0] & EN_MASK),
    .chg(chg), .master_q(master_q), .status_q(status_q),
    .enable_q(enable_q), .irq_q(irq_q)
  );

  always_comb begin
    b1_rd32 = '0; b1_rd32[CH1_WIDTH-1:0] = b1_rd;
    b1_dir32 = '0; b1_dir32[CH1_WIDTH-1:0] = b1_dir;
    b2_rd32 = '0; b2_rd32[CH2_WIDTH-1:0] = b2_rd;
    b2_dir32 = '0; b2_dir32[CH2_WIDTH-1:0] = b2_dir;
    mux = '0;
    if (hit_b1d) mux = b1_rd32;
    if (hit_b1r) mux = b1_dir32;
    if (hit_b2d) mux = b2_rd32;
    if (hit_b2r) mux = b2_dir32;
    if (hit_m)   mux[MASTER_BIT] = master_q;
    if (hit_s)   mux[NUM_BANKS-1:0] = status_q;
    if (hit_e)   mux[NUM_BANKS-1:0] = enable_q;
  end

  assign bus_rdata = (bus_en && !bus_wr) ? mux : '0;
  assign irq = irq_q;

  // R12
  single_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !DUAL |-> !enable_q[1]);
endmodule

// File: tb/tb_gpio_dual_ctrl.sv
module tb_gpio_dual_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_en = 1'b0, bus_wr = 1'b0;
  logic [8:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rdata, rdata_s;
  logic [31:0] ch1_out, ch1_oe, ch1_in;
  logic [7:0]  ch2_out, ch2_oe, ch2_in;
  logic irq;
  logic [31:0] s1_out, s1_oe, s2_out, s2_oe;
  logic irq_s;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gpio_dual_ctrl #(.CH2_WIDTH(8)) dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata),
    .ch1_out(ch1_out), .ch1_oe(ch1_oe), .ch1_in(ch1_in),
    .ch2_out(ch2_out), .ch2_oe(ch2_oe), .ch2_in(ch2_in), .irq(irq));

  gpio_dual_ctrl #(.DUAL(1'b0)) dut_single (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_s),
    .ch1_out(s1_out), .ch1_oe(s1_oe), .ch1_in(32'h0),
    .ch2_out(s2_out), .ch2_oe(s2_oe), .ch2_in(32'h0), .irq(irq_s));

  // {write?, addr, wdata, expected read}
  localparam int NV = 12;
  localparam logic [73:0] VEC [NV] = '{
    {1'b1, 9'h004, 32'h0000_FFFF, 32'h0000_FFFF},  // R3 bank1 dir
    {1'b1, 9'h000, 32'h1234_5678, 32'h1234_0011},  // R2 R4 mixed
    {1'b1, 9'h00C, 32'hFFFF_FFF0, 32'h0000_00F0},  // R3 R4 width 8
    {1'b1, 9'h008, 32'hFFFF_FFAB, 32'h0000_000B},  // R2 R4
    {1'b1, 9'h11C, 32'h7FFF_FFFF, 32'h0000_0000},  // R8 low bits ignored
    {1'b1, 9'h11C, 32'h8000_0001, 32'h8000_0000},  // R8
    {1'b1, 9'h128, 32'hFFFF_FFFF, 32'h0000_0003},  // R9
    {1'b1, 9'h010, 32'hFFFF_FFFF, 32'h0000_0000},  // R10
    {1'b1, 9'h124, 32'hFFFF_FFFF, 32'h0000_0000},  // R10
    {1'b1, 9'h002, 32'hFFFF_FFFF, 32'h0000_0000},  // R10 misaligned
    {1'b0, 9'h004, 32'h0,         32'h0000_FFFF},  // R10 no side effect
    {1'b0, 9'h000, 32'h0,         32'h1234_0011}   // R10 no side effect
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    bus_en = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_en = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d, output logic [31:0] ds);
    bus_en = 1; bus_wr = 0; bus_addr = a;
    #1; d = rdata; ds = rdata_s;
    bus_en = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, vs;
    ch1_in = 32'h0000_0011;
    ch2_in = 8'h00;
    tick(3);
    rst_n = 1;
    tick(6);
    // R1 reset state
    check("R1 ch1_oe", ch1_oe, 32'h0);
    check("R1 ch1_out", ch1_out, 32'h0);
    check("R1 irq", {31'h0, irq}, 32'h0);
    rd(9'h004, v, vs); check("R1 dir reset", v, 32'hFFFF_FFFF);
    rd(9'h00C, v, vs); check("R1 bank2 dir reset", v, 32'h0000_00FF);
    // R11 nonzero pins during reset raised no event
    rd(9'h120, v, vs); check("R11 status after fill", v, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][73]) wr(VEC[i][72:64], VEC[i][63:32]);
      rd(VEC[i][72:64], v, vs);
      check($sformatf("R2/R3/R4/R8/R9/R10 vec %0d", i), v, VEC[i][31:0]);
    end

    check("R2 ch1_out", ch1_out, 32'h1234_5678);
    check("R3 ch1_oe", ch1_oe, 32'hFFFF_0000);
    check("R2 ch2_out", {24'h0, ch2_out}, 32'h0000_00AB);
    check("R3 ch2_oe", {24'h0, ch2_oe}, 32'h0000_000F);

    // R5 / R7 timing of a bank-1 pin change
    ch1_in = 32'h0000_0010;
    tick(2);
    rd(9'h000, v, vs); check("R4 pin visible after 2 edges", v, 32'h1234_0010);
    rd(9'h120, v, vs); check("R5 status not yet set", v, 32'h0);
    tick(1);
    rd(9'h120, v, vs); check("R5 status set on edge 3", v, 32'h1);
    check("R7 irq not yet", {31'h0, irq}, 32'h0);
    tick(1);
    check("R7 irq raised", {31'h0, irq}, 32'h1);
    // R6 writing zero keeps the bit
    wr(9'h120, 32'h0);
    rd(9'h120, v, vs); check("R6 zero write keeps", v, 32'h1);
    wr(9'h120, 32'h1);
    rd(9'h120, v, vs); check("R6 ack clears", v, 32'h0);
    check("R7 irq lags ack", {31'h0, irq}, 32'h1);
    tick(1);
    check("R7 irq dropped", {31'h0, irq}, 32'h0);

    // R5 / R7 enable gating on bank 2
    wr(9'h128, 32'h1);
    ch2_in = 8'h80;
    tick(4);
    rd(9'h120, v, vs); check("R5 bank2 status while disabled", v, 32'h2);
    check("R7 masked irq", {31'h0, irq}, 32'h0);
    wr(9'h128, 32'h3);
    tick(1);
    check("R7 irq after enable", {31'h0, irq}, 32'h1);
    wr(9'h11C, 32'h0);
    tick(1);
    check("R8 master off drops irq", {31'h0, irq}, 32'h0);
    wr(9'h120, 32'h2);
    rd(9'h120, v, vs); check("R6 bank2 ack", v, 32'h0);
    wr(9'h11C, 32'h8000_0000);

    // R6 clear and new change in the same cycle
    ch1_in = 32'h0000_0011;
    tick(3);
    rd(9'h120, v, vs); check("R5 second change", v, 32'h1);
    ch1_in = 32'h0000_0010;
    tick(2);
    wr(9'h120, 32'h1);
    rd(9'h120, v, vs); check("R6 change beats clear", v, 32'h1);
    wr(9'h120, 32'h1);
    rd(9'h120, v, vs); check("R6 final clear", v, 32'h0);

    // R12 single-bank instance
    rd(9'h008, v, vs); check("R12 bank2 data unmapped", vs, 32'h0);
    rd(9'h00C, v, vs); check("R12 bank2 dir unmapped", vs, 32'h0);
    rd(9'h128, v, vs); check("R12 enable bit1 absent", vs, 32'h1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule